// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A single-port synchronous word memory whose data phase always falls a fixed two enabled clock edges after its command, for reads and writes alike. Because write data is taken in the same slot where read data would appear, a controller can mix reads and writes in any order on every cycle with no idle cycles on the data bus. The data bus is split into an input bus and an output bus with a drive flag, so no bidirectional pad is modelled.

Each command carries an address, a read/write select and per-lane write enables. Three chip selects gate new commands, and a clock enable stalls the whole pipeline. An internal four-beat burst counter lets a single loaded address be followed by advance cycles that step through the rest of its aligned group of four words, in linear or interleaved order. An asynchronous output enable can cut the output drive at any time. Words are four 9-bit lanes: eight data bits plus a parity bit, which the memory stores without interpreting it.

Top module: `zbt_sram`

## Requirements
- R1: A read command accepted at enabled edge k puts the addressed word on `rdata_o` with `rdrive_o` high from enabled edge k+2 until the next enabled edge.
- R2: For a write command accepted at enabled edge k, `wdata_i` is sampled at enabled edge k+2. Reads and writes may follow each other on consecutive cycles in any order with no idle cycle.
- R3: While `cen_ni` is high, every input except `oe_ni` and `rst_ni` is ignored. No memory word changes, no pipeline or burst state moves, and `rdata_o`/`rdrive_o` hold their values.
- R4: A load cycle (`adv_i` low) issues a command only when `sel_a_ni` is low, `sel_b_i` is high and `sel_c_ni` is low. With any select inactive, no access happens.
- R5: A deselect or a stall never cancels a command already accepted. Each command completes at its own scheduled data edge.
- R6: `rdrive_o` is low after enabled edge k+2 when the cycle at edge k was a write, a deselect, or an advance with no active burst.
- R7: `oe_ni` high forces `rdrive_o` low and `rdata_o` to zero at once, without waiting for a clock edge, whatever the pipeline holds.
- R8: Write enable bit `bwe_i[l]` (active high) selects lane l, which is bits [9l+8:9l] of the word. Only the enabled lanes of the addressed word are written.
- R9: An advance cycle (`adv_i` high) repeats the read/write direction of the last loaded command and takes `bwe_i` from the current cycle. It ignores the chip selects and `addr_i`. Its address keeps the upper bits of the loaded base. Its two low bits are (base+n) mod 4 when `order_i` is 1 (linear) and base XOR n when `order_i` is 0 (interleaved), for beat n = 1, 2, 3, wrapping after 3. An advance after a load that was deselected issues nothing.
- R10: Reset (`rst_ni` low, asynchronous) clears all pending commands, the burst state and the output drive. Memory contents are kept.
- R11: A read issued one or two cycles after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low; high stalls everything |
| sel_a_ni | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_ni | input | 1 | Chip select, active low |
| adv_i | input | 1 | 1: advance burst, 0: load new command |
| wr_i | input | 1 | 1: write, 0: read (load cycles only) |
| order_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| bwe_i | input | LANES | Per-lane write enables, active high |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data, sampled two edges after its command |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| rdrive_o | output | 1 | Read data valid / output drive |

## Verification
The bench goes after the two-edge data slot. A design that took write data with its command, or that read one edge early, would store or return the wrong word in the read-after-write and write-after-read runs. Stalls placed with commands in flight, with garbage inputs present during the stall, catch any register that keeps moving: a write would land in the wrong edge, or a stray write would appear in the final full-memory read sweep. Deselects after reads and partial selects check that pending work completes while new work is refused. Bursts in both orders from every base offset, with advance cycles that carry inactive selects, catch a wrong sequence or a burst that listens to the selects. Masked lane writes, asynchronous output enable mid-cycle, and a reset in the middle of traffic followed by a read sweep check lane isolation, immediate release of the drive, and memory kept across reset.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

  localparam int unsigned BURST_W = 2;

  typedef enum logic {
    ORDER_INTERLEAVE = 1'b0,
    ORDER_LINEAR     = 1'b1
  } burst_order_e;

  function automatic logic [BURST_W-1:0] burst_ofs(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] beat,
    input burst_order_e       order
  );
    return (order == ORDER_LINEAR) ? base + beat : base ^ beat;
  endfunction

endpackage

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen
  import zbt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              sel_ok_i,
  input  logic              wr_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bwe_i,
  output logic              cmd_vld_o,
  output logic              cmd_wr_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LANES-1:0]  cmd_bwe_o
);

  logic               active_q;
  logic               wr_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] beat_nxt;
  logic [ADDR_W-1:0]  seq_addr;

  assign beat_nxt = beat_q + 1'b1;
  assign seq_addr = {base_q[ADDR_W-1:BURST_W],
                     burst_ofs(base_q[BURST_W-1:0], beat_nxt, burst_order_e'(order_i))};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      wr_q       <= 1'b0;
      base_q     <= '0;
      beat_q     <= '0;
      cmd_vld_o  <= 1'b0;
      cmd_wr_o   <= 1'b0;
      cmd_addr_o <= '0;
      cmd_bwe_o  <= '0;
    end else if (en_i) begin
      cmd_bwe_o <= bwe_i;
      if (load_i) begin
        active_q  <= sel_ok_i;
        cmd_vld_o <= sel_ok_i;
        if (sel_ok_i) begin
          wr_q       <= wr_i;
          base_q     <= addr_i;
          beat_q     <= '0;
          cmd_wr_o   <= wr_i;
          cmd_addr_o <= addr_i;
        end
      end else if (active_q) begin
        beat_q     <= beat_nxt;
        cmd_vld_o  <= 1'b1;
        cmd_wr_o   <= wr_q;
        cmd_addr_o <= seq_addr;
      end else begin
        cmd_vld_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] data_o
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic             in_v;
    logic [WIDTH-1:0] in_d;
    logic             v_q;
    logic [WIDTH-1:0] d_q;

    if (g == 0) begin : g_head
      assign in_v = vld_i;
      assign in_d = data_i;
    end else begin : g_tail
      assign in_v = g_stage[g-1].v_q;
      assign in_d = g_stage[g-1].d_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (en_i) begin
        v_q <= in_v;
        d_q <= in_d;
      end
    end
  end

  assign vld_o  = g_stage[STAGES-1].v_q;
  assign data_o = g_stage[STAGES-1].d_q;

endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    vld_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        bwe_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] rd_word;
  logic              do_read;

  assign do_read = en_i & vld_i & ~wr_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (en_i && vld_i && wr_i && bwe_i[l]) begin
        mem_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end

    assign rd_word[l*LANE_W +: LANE_W] = mem_q[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_o <= 1'b0;
      rdata_o <= '0;
    end else if (en_i) begin
      drive_o <= vld_i & ~wr_i;
      if (do_read) rdata_o <= rd_word;
    end
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cen_ni,
  input  logic                    sel_a_ni,
  input  logic                    sel_b_i,
  input  logic                    sel_c_ni,
  input  logic                    adv_i,
  input  logic                    wr_i,
  input  logic                    order_i,
  input  logic [LANES-1:0]        bwe_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_ni,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdrive_o
);

  localparam int unsigned WORD_W = LANES * LANE_W;
  localparam int unsigned PAY_W  = 1 + ADDR_W + LANES;

  logic              en;
  logic              sel_ok;
  logic              s1_vld, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_bwe;
  logic              s2_vld, s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_bwe;
  logic [PAY_W-1:0]  s2_pay;
  logic [WORD_W-1:0] rdata_q;
  logic              drive_q;

  assign en     = ~cen_ni;
  assign sel_ok = ~sel_a_ni & sel_b_i & ~sel_c_ni;

  zbt_burst_gen #(
    .ADDR_W(ADDR_W),
    .LANES (LANES)
  ) u_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .load_i    (~adv_i),
    .sel_ok_i  (sel_ok),
    .wr_i      (wr_i),
    .order_i   (order_i),
    .addr_i    (addr_i),
    .bwe_i     (bwe_i),
    .cmd_vld_o (s1_vld),
    .cmd_wr_o  (s1_wr),
    .cmd_addr_o(s1_addr),
    .cmd_bwe_o (s1_bwe)
  );

  zbt_cmd_pipe #(
    .WIDTH (PAY_W),
    .STAGES(1)
  ) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .vld_i (s1_vld),
    .data_i({s1_wr, s1_addr, s1_bwe}),
    .vld_o (s2_vld),
    .data_o(s2_pay)
  );

  assign {s2_wr, s2_addr, s2_bwe} = s2_pay;

  zbt_mem_array #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .vld_i  (s2_vld),
    .wr_i   (s2_wr),
    .addr_i (s2_addr),
    .bwe_i  (s2_bwe),
    .wdata_i(wdata_i),
    .rdata_o(rdata_q),
    .drive_o(drive_q)
  );

  // output enable acts without a clock edge
  assign rdrive_o = drive_q & ~oe_ni;
  assign rdata_o  = rdrive_o ? rdata_q : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cen_ni,
  input logic adv_i,
  input logic sel_ok,
  input logic oe_ni,
  input logic rdrive_o,
  input logic s1_vld,
  input logic s2_vld,
  input logic s2_wr,
  input logic drive_q
);

  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen_ni && s2_vld && !s2_wr |=> drive_q); // R1

  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> $stable(s1_vld) && $stable(s2_vld) && $stable(drive_q)); // R3

  AST_DESEL_NO_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen_ni && !adv_i && !sel_ok |=> !s1_vld); // R4

  AST_INFLIGHT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen_ni && s1_vld |=> s2_vld); // R5

  AST_WRITE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen_ni && s2_vld && s2_wr |=> !drive_q); // R6

  AST_OE_FORCES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rdrive_o); // R7

endmodule

bind zbt_sram zbt_sram_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cen_ni  (cen_ni),
  .adv_i   (adv_i),
  .sel_ok  (sel_ok),
  .oe_ni   (oe_ni),
  .rdrive_o(rdrive_o),
  .s1_vld  (s1_vld),
  .s2_vld  (s2_vld),
  .s2_wr   (s2_wr),
  .drive_q (drive_q)
);

// File: tb/zbt_sram_tb_top.sv
module zbt_sram_tb_top;

  localparam int AW    = 8;
  localparam int LN    = 4;
  localparam int LW    = 9;
  localparam int WW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk_i    = 1'b0;
  logic          rst_ni   = 1'b0;
  logic          cen_ni   = 1'b0;
  logic          sel_a_ni = 1'b0;
  logic          sel_b_i  = 1'b1;
  logic          sel_c_ni = 1'b0;
  logic          adv_i    = 1'b0;
  logic          wr_i     = 1'b0;
  logic          order_i  = 1'b1;
  logic          oe_ni    = 1'b0;
  logic [LN-1:0] bwe_i    = '1;
  logic [AW-1:0] addr_i   = '0;
  logic [WW-1:0] wdata_i  = '0;
  logic [WW-1:0] rdata_o;
  logic          rdrive_o;

  always #5 clk_i = ~clk_i;

  zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk_i, .rst_ni, .cen_ni, .sel_a_ni, .sel_b_i, .sel_c_ni, .adv_i, .wr_i,
    .order_i, .bwe_i, .addr_i, .wdata_i, .oe_ni, .rdata_o, .rdrive_o
  );

  typedef struct {
    bit          v;
    bit          w;
    int          a;
    bit [LN-1:0] be;
  } op_t;

  op_t           pq[$];
  logic [WW-1:0] mm [DEPTH];
  bit            exp_drv;
  logic [WW-1:0] exp_dat;
  bit            b_act, b_wr;
  int            b_base, b_cnt;
  int            salt;
  int            n_chk = 0, n_err = 0;
  bit            done = 0;

  function automatic logic [WW-1:0] pat(int a);
    return {salt[3:0], a[7:0], a[7:0] ^ 8'hA5, 8'(salt * 3 + a), ~a[7:0]};
  endfunction

  task automatic chk(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic mdl_reset();
    op_t z;
    z.v = 0; z.w = 0; z.a = 0; z.be = '0;
    pq.delete();
    repeat (2) pq.push_back(z);
    b_act = 0; b_cnt = 0; exp_drv = 0;
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(bit cen, bit adv, bit [2:0] sel, bit wr, int a,
                     bit [LN-1:0] be, bit oe, bit ord, string req);
    op_t d, n;
    cen_ni = cen; adv_i = adv; {sel_a_ni, sel_b_i, sel_c_ni} = sel;
    wr_i = wr; addr_i = AW'(a); bwe_i = be; oe_ni = oe; order_i = ord;
    wdata_i = pq[0].v ? pat(pq[0].a) : WW'({$urandom, $urandom});
    @(posedge clk_i);
    if (!cen) begin
      d = pq.pop_front();
      exp_drv = d.v && !d.w;
      if (d.v && d.w)
        for (int l = 0; l < LN; l++)
          if (d.be[l]) mm[d.a][l*LW +: LW] = wdata_i[l*LW +: LW];
      if (exp_drv) exp_dat = mm[d.a];
      n.v = 0; n.w = 0; n.a = 0; n.be = be;
      if (!adv) begin
        if (sel == 3'b010) begin
          b_act = 1; b_base = a; b_cnt = 0; b_wr = wr;
          n.v = 1; n.w = wr; n.a = a;
        end else b_act = 0;
      end else if (b_act) begin
        b_cnt = (b_cnt + 1) % 4;
        n.v = 1; n.w = b_wr;
        n.a = (b_base & ~3) | (ord ? ((b_base + b_cnt) % 4) : ((b_base % 4) ^ b_cnt));
      end
      pq.push_back(n);
    end
    @(negedge clk_i);
    chk({req, " drive"}, WW'(rdrive_o), WW'(exp_drv && !oe));
    chk({req, " data"}, rdata_o, (exp_drv && !oe) ? exp_dat : '0);
  endtask

  task automatic rd(int a, string r);
    cyc(0, 0, 3'b010, 0, a, '1, 0, 1, r);
  endtask
  task automatic wrt(int a, bit [LN-1:0] be, string r);
    cyc(0, 0, 3'b010, 1, a, be, 0, 1, r);
  endtask
  task automatic idle(string r);
    cyc(0, 0, 3'b110, 0, 0, '1, 0, 1, r);
  endtask
  task automatic burst(bit ord, bit wr, int base, string r);
    cyc(0, 0, 3'b010, wr, base, '1, 0, ord, r);
    cyc(0, 1, 3'b101, ~wr, 255, 4'b1011, 0, ord, r); // selects and direction ignored
    cyc(0, 1, 3'b000, ~wr, 0, '1, 0, ord, r);
    cyc(0, 1, 3'b010, ~wr, 17, 4'b0110, 0, ord, r);
  endtask

  task automatic do_reset(string r);
    rst_ni = 1'b0;
    #1;
    chk({r, " async drive"}, WW'(rdrive_o), '0);
    @(negedge clk_i);
    chk({r, " data"}, rdata_o, '0);
    rst_ni = 1'b1;
    mdl_reset();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    mdl_reset();
    salt = 1;
    repeat (2) @(negedge clk_i);
    chk("R10 reset drive", WW'(rdrive_o), '0);
    chk("R10 reset data", rdata_o, '0);
    rst_ni = 1'b1;

    // fill every word, writes back to back
    for (int a = 0; a < DEPTH; a++) wrt(a, '1, "R2");
    idle("R2"); idle("R2");

    // read right after write, same address, then one gap
    salt = 2;
    for (int i = 0; i < 32; i++) begin wrt(i * 7 % DEPTH, '1, "R11"); rd(i * 7 % DEPTH, "R11"); end
    wrt(50, '1, "R11"); idle("R11"); rd(50, "R11"); idle("R11"); idle("R11");
    // write after read, alternating
    salt = 3;
    for (int i = 0; i < 24; i++) begin rd(i, "R2"); wrt(100 + i, '1, "R2"); end
    for (int i = 0; i < 24; i++) rd(100 + i, "R1");
    idle("R1"); idle("R1");

    // lane enables
    salt = 4;
    wrt(10, 4'b0101, "R8"); wrt(11, 4'b1000, "R8"); wrt(12, 4'b0000, "R8");
    rd(10, "R8"); rd(11, "R8"); rd(12, "R8"); idle("R8"); idle("R8");

    // stall with commands in flight and garbage inputs
    salt = 5;
    wrt(20, '1, "R3"); rd(21, "R3");
    repeat (3) cyc(1, 0, 3'b010, 1, 77, '1, 0, 1, "R3");
    rd(20, "R3");
    repeat (2) cyc(1, 1, 3'b010, 1, 78, '1, 0, 1, "R3");
    idle("R3"); idle("R3"); rd(77, "R3"); rd(78, "R3"); idle("R3"); idle("R3");

    // partial selects issue nothing
    salt = 6;
    cyc(0, 0, 3'b110, 1, 30, '1, 0, 1, "R4");
    cyc(0, 0, 3'b000, 1, 30, '1, 0, 1, "R4");
    cyc(0, 0, 3'b011, 1, 30, '1, 0, 1, "R4");
    cyc(0, 0, 3'b100, 0, 31, '1, 0, 1, "R4");
    idle("R4"); rd(30, "R4"); idle("R4"); idle("R4");

    // deselect and stall behind pending reads
    rd(1, "R5"); rd(2, "R5"); idle("R5");
    cyc(1, 0, 3'b110, 0, 0, '1, 0, 1, "R5");
    idle("R5"); idle("R5");

    // drive release after write and deselect
    rd(5, "R6"); wrt(6, '1, "R6"); rd(7, "R6"); idle("R6"); rd(8, "R6");
    cyc(0, 1, 3'b010, 0, 0, '1, 0, 1, "R6"); idle("R6"); idle("R6"); idle("R6");

    // output enable
    rd(9, "R7"); idle("R7"); idle("R7");
    // drive from the read is now on; cut it mid-cycle
    oe_ni = 1'b1; #1;
    chk("R7 oe mid-cycle drive", WW'(rdrive_o), '0);
    chk("R7 oe mid-cycle data", rdata_o, '0);
    oe_ni = 1'b0; #1;
    chk("R7 oe release drive", WW'(rdrive_o), WW'(1));
    rd(9, "R7"); rd(10, "R7");
    cyc(0, 0, 3'b110, 0, 0, '1, 1, 1, "R7");
    cyc(0, 0, 3'b110, 0, 0, '1, 1, 1, "R7");
    idle("R7");

    // bursts, both orders, every base offset
    for (int o = 0; o < 2; o++) begin
      for (int b = 0; b < 4; b++) begin
        salt = 7 + o * 4 + b;
        burst(o[0], 1, 40 + b, "R9");
        burst(o[0], 0, 40 + b, "R9");
        idle("R9");
      end
    end
    cyc(0, 0, 3'b110, 1, 60, '1, 0, 1, "R9");
    cyc(0, 1, 3'b010, 1, 61, '1, 0, 1, "R9");
    cyc(0, 1, 3'b010, 1, 62, '1, 0, 1, "R9");
    idle("R9"); idle("R9");
    for (int a = 40; a < 48; a++) rd(a, "R9");
    for (int a = 60; a < 64; a++) rd(a, "R9");
    idle("R9"); idle("R9");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      bit [2:0] sel;
      if (i % 100 == 0) salt = salt + 1;
      sel = ($urandom % 5 == 0) ? 3'($urandom) : 3'b010;
      cyc(($urandom % 12) == 0, ($urandom % 3) == 0, sel, $urandom % 2,
          $urandom % DEPTH, LN'($urandom), ($urandom % 10) == 0, $urandom % 2, "R1");
    end

    // reset mid-traffic keeps memory
    wrt(3, '1, "R10"); rd(4, "R10");
    do_reset("R10");
    idle("R10"); idle("R10");
    for (int a = 0; a < DEPTH; a++) rd(a, "R10");
    idle("R10"); idle("R10");

    finish_run();
  end

endmodule